// File: doc/BRIEF.md
# Lockable Two-Stage APB Watchdog

This block is a down-counting watchdog on an APB slave port. Its counter steps down once for every clock cycle in which the watchdog tick input is high. The first time the count runs out, the block raises an interrupt and reloads. If software has not cleared that interrupt by the next time the count runs out, the block raises a reset request and the counter halts.

Software feeds the watchdog in one of two ways. It can clear the interrupt, which also reloads the counter, or it can write a new load value. A key register guards every other register against stray writes. A test mode lets software set both outputs straight from a register. A small bank of read-only identification words completes the map. Every transfer finishes in its access cycle, and the error response is never used.

Top module: `wdt_apb`

## Requirements
- R1: After reset the load value and the current count are 0xFFFFFFFF with counting enabled. Control, lock, test control, test output, the raw interrupt flag and the reset status are all zero, and both outputs are low.
- R2: `pready` is always 1 and `pslverr` is always 0. A write takes effect at the clock edge that ends its access cycle. A read returns data in its access cycle.
- R3: A write to offset 0x000 sets both the load value and the current count to the written data and restarts counting, even after the counter has halted. The load value reads back at 0x000.
- R4: The count, read at 0x004, drops by one only on a cycle where `wd_tick` is high and the counter is running. Without a tick and without a load or clear write, it holds.
- R5: An expiry is a tick while the count is zero and the counter is running. If the raw interrupt flag is clear at expiry, the flag is set and the count reloads from the load value. The raw flag reads in bit 0 of offset 0x010.
- R6: An expiry while the raw flag is already set sets the reset status and halts the counter. The count then stays where it is under further ticks. The reset status is cleared only by reset.
- R7: A write of any data to offset 0x00C clears the raw flag and reloads the count from the load value. The offset reads as zero.
- R8: Control at offset 0x008 keeps only bit 0 (interrupt enable) and bit 1 (reset enable), and its other bits read as zero. Outside test mode, `wdog_irq` is the raw flag AND bit 0, and `wdog_rst_req` is the reset status AND bit 1. Offset 0x014 reads the gated interrupt in bit 0.
- R9: A write of 0x1ACCE551 to offset 0xC00 unlocks the block, and a write of any other value locks it. Offset 0xC00 reads 1 when locked and 0 when unlocked.
- R10: While locked, writes to every offset other than 0xC00 are dropped.
- R11: While bit 0 of offset 0xF00 is set, `wdog_rst_req` follows bit 0 and `wdog_irq` follows bit 1 of the write-only test-output register at 0xF04. The status-derived outputs are ignored while this mode is on.
- R12: The identification words read as 0x04, 0x00, 0x00, 0x00 at 0xFD0, 0xFD4, 0xFD8 and 0xFDC. They read as 0x24, 0xB8, 0x1B, 0x00 at 0xFE0 to 0xFEC, and as 0x0D, 0xF0, 0x05, 0xB1 at 0xFF0 to 0xFFC.
- R13: Reads of 0x00C, 0xF04, any unmapped offset, or any offset whose low two bits are nonzero return zero. Writes to the read-only offsets (0x004, 0x010, 0x014 and the identification words) and to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when high |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Error response, always low |
| wd_tick | input | 1 | Counter clock enable |
| wdog_irq | output | 1 | Level interrupt |
| wdog_rst_req | output | 1 | Reset request |

## Verification
The bench builds the block with its default 32-bit counter and 12-bit address. It reaches both expiries by writing load values of seven or less, so a full two-stage timeout takes only a handful of ticks. The counter is never run through its full 32-bit range. Since the bench owns the tick input, the expected count is exact at every read. This holds for directed cases such as the second expiry, a halted counter and writes under lock, and for a seeded random mix of ticks, loads, clears, control, key and test-mode writes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned DATA_W = 32;

  // byte offsets of the register map
  localparam int unsigned OFF_LOAD   = 'h000;
  localparam int unsigned OFF_VALUE  = 'h004;
  localparam int unsigned OFF_CTRL   = 'h008;
  localparam int unsigned OFF_CLEAR  = 'h00C;
  localparam int unsigned OFF_RAW    = 'h010;
  localparam int unsigned OFF_MASKED = 'h014;
  localparam int unsigned OFF_KEY    = 'hC00;
  localparam int unsigned OFF_TMODE  = 'hF00;
  localparam int unsigned OFF_TOUT   = 'hF04;
  localparam int unsigned OFF_ID_LO  = 'hFD0;
  localparam int unsigned ID_WORDS   = 12;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACC_E551;

  typedef struct packed {
    logic rst_en;
    logic irq_en;
  } ctrl_t;

  function automatic logic [7:0] id_byte(input logic [3:0] idx);
    logic [7:0] b;
    case (idx)
      4'd0:  b = 8'h04;
      4'd4:  b = 8'h24;
      4'd5:  b = 8'hB8;
      4'd6:  b = 8'h1B;
      4'd8:  b = 8'h0D;
      4'd9:  b = 8'hF0;
      4'd10: b = 8'h05;
      4'd11: b = 8'hB1;
      default: b = 8'h00;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              load_wr,
  input  logic              clear_wr,
  input  logic [CNT_W-1:0]  wdata,
  output logic [CNT_W-1:0]  load_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              run_q,
  output logic              raw_q,
  output logic              rstat_q
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] load_d, count_d;
  logic             run_d, raw_d, rstat_d;
  logic             at_zero;

  assign at_zero = (count_q == '0);

  always_comb begin
    load_d  = load_q;
    count_d = count_q;
    run_d   = run_q;
    raw_d   = raw_q;
    rstat_d = rstat_q;
    if (load_wr) begin
      load_d  = wdata;
      count_d = wdata;
      run_d   = 1'b1;
    end else if (clear_wr) begin
      raw_d   = 1'b0;
      count_d = load_q;
    end else if (tick && run_q) begin
      if (!at_zero) begin
        count_d = count_q - 1'b1;
      end else if (!raw_q) begin
        raw_d   = 1'b1;
        count_d = load_q;
      end else begin
        rstat_d = 1'b1;
        run_d   = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q  <= CNT_MAX;
      count_q <= CNT_MAX;
      run_q   <= 1'b1;
      raw_q   <= 1'b0;
      rstat_q <= 1'b0;
    end else begin
      load_q  <= load_d;
      count_q <= count_d;
      run_q   <= run_d;
      raw_q   <= raw_d;
      rstat_q <= rstat_d;
    end
  end

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic [CNT_W-1:0]  load_q,
  input  logic [CNT_W-1:0]  count_q,
  input  logic              raw_q,
  output logic              load_wr,
  output logic              clear_wr,
  output ctrl_t             ctrl_q,
  output logic              lock_q,
  output logic              tmode_q,
  output logic [1:0]        tout_q
);

  localparam int unsigned ID_FIRST = OFF_ID_LO;
  localparam int unsigned ID_LAST  = OFF_ID_LO + 4 * (ID_WORDS - 1);

  logic        access_wr, wr_ok;
  logic        hit_load, hit_value, hit_ctrl, hit_clear, hit_raw, hit_masked;
  logic        hit_key, hit_tmode, hit_tout, hit_id;
  logic        aligned;
  logic [3:0]  id_idx;
  ctrl_t       ctrl_d;
  logic        lock_d, tmode_d;
  logic [1:0]  tout_d;

  assign aligned    = (paddr[1:0] == 2'b00);
  assign hit_load   = aligned && (paddr == ADDR_W'(OFF_LOAD));
  assign hit_value  = aligned && (paddr == ADDR_W'(OFF_VALUE));
  assign hit_ctrl   = aligned && (paddr == ADDR_W'(OFF_CTRL));
  assign hit_clear  = aligned && (paddr == ADDR_W'(OFF_CLEAR));
  assign hit_raw    = aligned && (paddr == ADDR_W'(OFF_RAW));
  assign hit_masked = aligned && (paddr == ADDR_W'(OFF_MASKED));
  assign hit_key    = aligned && (paddr == ADDR_W'(OFF_KEY));
  assign hit_tmode  = aligned && (paddr == ADDR_W'(OFF_TMODE));
  assign hit_tout   = aligned && (paddr == ADDR_W'(OFF_TOUT));
  assign hit_id     = aligned && (paddr >= ADDR_W'(ID_FIRST)) && (paddr <= ADDR_W'(ID_LAST));
  assign id_idx     = 4'((paddr - ADDR_W'(ID_FIRST)) >> 2);

  assign access_wr = psel && penable && pwrite;
  assign wr_ok     = access_wr && (!lock_q || hit_key);
  assign load_wr   = wr_ok && hit_load;
  assign clear_wr  = wr_ok && hit_clear;

  always_comb begin
    ctrl_d  = ctrl_q;
    lock_d  = lock_q;
    tmode_d = tmode_q;
    tout_d  = tout_q;
    if (wr_ok) begin
      if (hit_ctrl)  ctrl_d  = ctrl_t'(pwdata[1:0]);
      if (hit_key)   lock_d  = (pwdata != UNLOCK_KEY);
      if (hit_tmode) tmode_d = pwdata[0];
      if (hit_tout)  tout_d  = pwdata[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      lock_q  <= 1'b0;
      tmode_q <= 1'b0;
      tout_q  <= 2'b00;
    end else begin
      ctrl_q  <= ctrl_d;
      lock_q  <= lock_d;
      tmode_q <= tmode_d;
      tout_q  <= tout_d;
    end
  end

  always_comb begin
    prdata = '0;
    if (hit_load)   prdata = DATA_W'(load_q);
    if (hit_value)  prdata = DATA_W'(count_q);
    if (hit_ctrl)   prdata = DATA_W'(ctrl_q);
    if (hit_raw)    prdata = DATA_W'(raw_q);
    if (hit_masked) prdata = DATA_W'(raw_q & ctrl_q.irq_en);
    if (hit_key)    prdata = DATA_W'(lock_q);
    if (hit_tmode)  prdata = DATA_W'(tmode_q);
    if (hit_id)     prdata = DATA_W'(id_byte(id_idx));
  end

endmodule

// File: rtl/wdt_outsel.sv
module wdt_outsel
  import wdt_pkg::*;
(
  input  logic       tmode,
  input  logic [1:0] tout,
  input  ctrl_t      ctrl,
  input  logic       raw,
  input  logic       rstat,
  output logic       irq,
  output logic       rst_req
);

  logic irq_func, rst_func;

  assign irq_func = raw & ctrl.irq_en;
  assign rst_func = rstat & ctrl.rst_en;

  always_comb begin
    if (tmode) begin
      irq     = tout[1];
      rst_req = tout[0];
    end else begin
      irq     = irq_func;
      rst_req = rst_func;
    end
  end

endmodule

// File: rtl/wdt_apb.sv
module wdt_apb
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic              wd_tick,
  output logic              wdog_irq,
  output logic              wdog_rst_req
);

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  logic [CNT_W-1:0] load_q, count_q;
  logic             run_q, raw_q, rstat_q;
  logic             load_wr, clear_wr;
  ctrl_t            ctrl_q;
  logic             lock_q, tmode_q;
  logic [1:0]       tout_q;

  assign pready  = 1'b1;
  assign pslverr = 1'b0;

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .pwdata   (pwdata),
    .prdata   (prdata),
    .load_q   (load_q),
    .count_q  (count_q),
    .raw_q    (raw_q),
    .load_wr  (load_wr),
    .clear_wr (clear_wr),
    .ctrl_q   (ctrl_q),
    .lock_q   (lock_q),
    .tmode_q  (tmode_q),
    .tout_q   (tout_q)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (wd_tick),
    .load_wr  (load_wr),
    .clear_wr (clear_wr),
    .wdata    (pwdata[CNT_W-1:0]),
    .load_q   (load_q),
    .count_q  (count_q),
    .run_q    (run_q),
    .raw_q    (raw_q),
    .rstat_q  (rstat_q)
  );

  wdt_outsel u_out (
    .tmode   (tmode_q),
    .tout    (tout_q),
    .ctrl    (ctrl_q),
    .raw     (raw_q),
    .rstat   (rstat_q),
    .irq     (wdog_irq),
    .rst_req (wdog_rst_req)
  );

endmodule

// File: rtl/wdt_apb_chk.sv
module wdt_apb_chk
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned CNT_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [31:0]       pwdata,
  input logic              wd_tick,
  input logic [CNT_W-1:0]  load_q,
  input logic [CNT_W-1:0]  count_q,
  input logic              run_q,
  input logic              raw_q,
  input logic              rstat_q,
  input logic              lock_q,
  input ctrl_t             ctrl_q
);

  logic wr;
  assign wr = psel && penable && pwrite;

  assert_hold_no_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_tick && !wr) |=> $stable(count_q));

  assert_first_expiry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && wd_tick && run_q && count_q == '0 && !raw_q) |=> (raw_q && count_q == $past(load_q)));

  assert_second_expiry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && wd_tick && run_q && count_q == '0 && raw_q) |=> (rstat_q && !run_q));

  assert_halted_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !wr) |=> $stable(count_q));

  assert_clear_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !lock_q && paddr == ADDR_W'(OFF_CLEAR)) |=> (!raw_q && count_q == $past(load_q)));

  assert_key_unlocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && paddr == ADDR_W'(OFF_KEY) && pwdata == UNLOCK_KEY) |=> !lock_q);

  assert_locked_ctrl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lock_q && paddr == ADDR_W'(OFF_CTRL)) |=> $stable(ctrl_q));

  assert_locked_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && lock_q && paddr == ADDR_W'(OFF_LOAD)) |=> $stable(load_q));

endmodule

bind wdt_apb wdt_apb_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .psel    (psel),
  .penable (penable),
  .pwrite  (pwrite),
  .paddr   (paddr),
  .pwdata  (pwdata),
  .wd_tick (wd_tick),
  .load_q  (load_q),
  .count_q (count_q),
  .run_q   (run_q),
  .raw_q   (raw_q),
  .rstat_q (rstat_q),
  .lock_q  (lock_q),
  .ctrl_q  (ctrl_q)
);

// File: tb/wdt_apb_bench.sv
module wdt_apb_bench;

  localparam int unsigned AW = 12;
  localparam logic [31:0] KEY = 32'h1ACC_E551;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          psel, penable, pwrite;
  logic [AW-1:0] paddr;
  logic [31:0]   pwdata, prdata;
  logic          pready, pslverr;
  logic          wd_tick;
  logic          wdog_irq, wdog_rst_req;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wdt_apb u_wdt_apb (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .wd_tick(wd_tick), .wdog_irq(wdog_irq),
    .wdog_rst_req(wdog_rst_req)
  );

  // reference model state, built from the requirements
  logic [31:0] m_load, m_cnt;
  logic        m_run, m_raw, m_rst, m_lock, m_tmode;
  logic [1:0]  m_ctrl, m_tout;

  function automatic void model_reset();
    m_load = 32'hFFFF_FFFF; m_cnt = 32'hFFFF_FFFF; m_run = 1'b1;
    m_raw = 1'b0; m_rst = 1'b0; m_lock = 1'b0; m_tmode = 1'b0;
    m_ctrl = 2'b00; m_tout = 2'b00;
  endfunction

  function automatic void model_tick();
    if (m_run) begin
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (!m_raw) begin m_raw = 1'b1; m_cnt = m_load; end
      else begin m_rst = 1'b1; m_run = 1'b0; end
    end
  endfunction

  function automatic void model_write(input logic [AW-1:0] a, input logic [31:0] d);
    if (m_lock && a != 12'hC00) return;
    case (a)
      12'h000: begin m_load = d; m_cnt = d; m_run = 1'b1; end
      12'h008: m_ctrl = d[1:0];
      12'h00C: begin m_raw = 1'b0; m_cnt = m_load; end
      12'hC00: m_lock = (d != KEY);
      12'hF00: m_tmode = d[0];
      12'hF04: m_tout = d[1:0];
      default: ;
    endcase
  endfunction

  function automatic logic exp_irq();
    return m_tmode ? m_tout[1] : (m_raw & m_ctrl[0]);
  endfunction

  function automatic logic exp_rst();
    return m_tmode ? m_tout[0] : (m_rst & m_ctrl[1]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    model_write(a, d);
  endtask

  task automatic apb_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #1;
    d = prdata;
    check("R2 pready", 32'(pready), 32'd1);
    check("R2 pslverr", 32'(pslverr), 32'd0);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    logic [31:0] d;
    apb_read(a, d);
    check(req, d, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); wd_tick = 1'b1;
      @(negedge clk); wd_tick = 1'b0;
      model_tick();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    model_reset();
  endtask

  task automatic check_outputs(input string req);
    check({req, " irq"}, 32'(wdog_irq), 32'(exp_irq()));
    check({req, " rst"}, 32'(wdog_rst_req), 32'(exp_rst()));
  endtask

  function automatic logic [7:0] exp_id(input int i);
    logic [7:0] t [12];
    t = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h24, 8'hB8, 8'h1B, 8'h00,
          8'h0D, 8'hF0, 8'h05, 8'hB1};
    return t[i];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; wd_tick = 0;
    rst_n = 1'b0;
    model_reset();
    do_reset();

    // R1 reset state
    read_check("R1 load", 12'h000, 32'hFFFF_FFFF);
    read_check("R1 value", 12'h004, 32'hFFFF_FFFF);
    read_check("R1 ctrl", 12'h008, 32'h0);
    read_check("R1 raw", 12'h010, 32'h0);
    read_check("R1 lock", 12'hC00, 32'h0);
    read_check("R1 tmode", 12'hF00, 32'h0);
    check("R1 irq", 32'(wdog_irq), 32'h0);
    check("R1 rst", 32'(wdog_rst_req), 32'h0);
    ticks(1);
    read_check("R1 running", 12'h004, 32'hFFFF_FFFE);

    // R3 load, R4 decrement and hold
    apb_write(12'h000, 32'd5);
    read_check("R3 load", 12'h000, 32'd5);
    read_check("R3 value", 12'h004, 32'd5);
    ticks(2);
    read_check("R4 after 2 ticks", 12'h004, 32'd3);
    repeat (5) @(negedge clk);
    read_check("R4 hold without tick", 12'h004, 32'd3);

    // R8 control masking
    apb_write(12'h008, 32'hFFFF_FFFF);
    read_check("R8 ctrl bits", 12'h008, 32'h3);
    ticks(3);
    read_check("R4 reach zero", 12'h004, 32'd0);
    check("R5 no early irq", 32'(wdog_irq), 32'd0);
    ticks(1);
    read_check("R5 raw set", 12'h010, 32'd1);
    read_check("R5 reload", 12'h004, 32'd5);
    check("R8 irq gated on", 32'(wdog_irq), 32'd1);
    read_check("R8 masked", 12'h014, 32'd1);

    // R7 clear
    apb_write(12'h00C, 32'h0);
    read_check("R7 raw cleared", 12'h010, 32'd0);
    read_check("R7 reload", 12'h004, 32'd5);
    check("R7 irq low", 32'(wdog_irq), 32'd0);
    read_check("R7 reads zero", 12'h00C, 32'd0);

    // R6 second expiry
    ticks(6);
    check("R5 irq again", 32'(wdog_irq), 32'd1);
    check("R6 no rst yet", 32'(wdog_rst_req), 32'd0);
    ticks(6);
    check("R6 rst asserted", 32'(wdog_rst_req), 32'd1);
    ticks(3);
    read_check("R6 halted", 12'h004, 32'd0);

    // R3 restart after halt, R8 gating
    apb_write(12'h000, 32'd4);
    read_check("R3 restart value", 12'h004, 32'd4);
    ticks(1);
    read_check("R3 restarted", 12'h004, 32'd3);
    apb_write(12'h008, 32'h1);
    check("R8 rst masked", 32'(wdog_rst_req), 32'd0);
    check("R8 irq enabled", 32'(wdog_irq), 32'd1);
    apb_write(12'h008, 32'h0);
    check("R8 irq masked", 32'(wdog_irq), 32'd0);
    read_check("R8 masked status", 12'h014, 32'd0);
    read_check("R8 raw stays", 12'h010, 32'd1);

    // R9 / R10 lock
    apb_write(12'hC00, 32'h0);
    read_check("R9 locked", 12'hC00, 32'd1);
    apb_write(12'h000, 32'd9);
    read_check("R10 load kept", 12'h000, 32'd4);
    apb_write(12'h008, 32'h3);
    read_check("R10 ctrl kept", 12'h008, 32'd0);
    apb_write(12'hF00, 32'h1);
    read_check("R10 tmode kept", 12'hF00, 32'd0);
    apb_write(12'h00C, 32'h0);
    read_check("R10 clear dropped", 12'h010, 32'd1);
    apb_write(12'hC00, KEY + 1);
    read_check("R9 near key locks", 12'hC00, 32'd1);
    apb_write(12'hC00, KEY);
    read_check("R9 unlocked", 12'hC00, 32'd0);

    // R11 test mode
    apb_write(12'hF00, 32'h1);
    apb_write(12'hF04, 32'h2);
    check("R11 irq from tout", 32'(wdog_irq), 32'd1);
    check("R11 rst from tout", 32'(wdog_rst_req), 32'd0);
    apb_write(12'hF04, 32'h1);
    check("R11 irq low", 32'(wdog_irq), 32'd0);
    check("R11 rst high", 32'(wdog_rst_req), 32'd1);
    read_check("R11 tmode reads", 12'hF00, 32'd1);
    read_check("R13 tout reads zero", 12'hF04, 32'd0);
    apb_write(12'hF00, 32'h0);
    check_outputs("R11 leave test");

    // R12 identification
    for (int i = 0; i < 12; i++)
      read_check("R12 id", AW'(12'hFD0 + 4 * i), 32'(exp_id(i)));

    // R13 unmapped, misaligned, read-only
    read_check("R13 unmapped", 12'h100, 32'd0);
    read_check("R13 misaligned", 12'h001, 32'd0);
    read_check("R13 below id", 12'hFCC, 32'd0);
    apb_write(12'h004, 32'h77);
    read_check("R13 value ro", 12'h004, 32'd3);
    apb_write(12'h010, 32'h0);
    read_check("R13 raw ro", 12'h010, 32'd1);
    apb_write(12'hFE0, 32'h0);
    read_check("R13 id ro", 12'hFE0, 32'h24);

    // seeded random mix against the model
    do_reset();
    void'($urandom(32'h00C0FFEE));
    for (int it = 0; it < 400; it++) begin
      int unsigned r;
      r = $urandom % 10;
      if (r < 5) ticks(1);
      else if (r == 5) apb_write(12'h000, $urandom % 7);
      else if (r == 6) apb_write(12'h00C, $urandom);
      else if (r == 7) apb_write(12'h008, $urandom);
      else if (r == 8) apb_write(12'hC00, (($urandom % 4) != 0) ? KEY : $urandom);
      else begin
        apb_write(12'hF04, $urandom);
        apb_write(12'hF00, 32'(($urandom % 4) == 0));
      end
      check_outputs("R8 R11 random");
      if (it % 8 == 0) begin
        read_check("R4 random value", 12'h004, m_cnt);
        read_check("R5 random raw", 12'h010, 32'(m_raw));
        read_check("R9 random lock", 12'hC00, 32'(m_lock));
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule